// File: doc/BRIEF.md
# Detector Event Frame Checker

This block receives one digitised detector event as two half-event word streams. Each half carries 64 channels. The block removes the framing from both halves and forwards the channel data to a downstream processor. After the data of each event it reports a status word that summarises how consistent that event was.

Every input word is 17 bits wide: 16 data bits and an even-parity bit. A half-event frame is made of the following words, in this order:

1. a start marker;
2. a bunch-crossing identifier;
3. an event identifier;
4. the channel samples (the number of samples per channel is programmable);
5. an end marker.

The block checks three things for each event:

- **Parity:** every word inside a frame must have even parity.
- **Half agreement:** both halves must carry the same identifiers.
- **Trigger reference:** the identifiers of half A must match a reference pair. The reference pairs arrive on a separate channel from the trigger-distribution path and are queued in a small FIFO.

Two kinds of event still have all their data forwarded: an event that contains errors, and an event whose frame is too long. In both cases only the status word reports the fault.

The two halves are consumed in strict alternation: one word from half A, then one word from half B. This makes the merged output an interleave of the two halves, one channel word at a time (A0, B0, A1, B1, …). No half has to be buffered.

Top module: `evt_frame_checker`

## Requirements
- R1: A half frame is accepted as the following words, with words taken alternately from half A and half B and `a_ready` and `b_ready` never high together:
  - the start marker 16'hB0E5;
  - a bunch-crossing word;
  - an event-ID word;
  - CH_PER_HALF × `cfg_samples` data words;
  - one trailer word.
- R2: Each data word is forwarded on `out_data` without its parity bit, in the order A0, B0, A1, B1, …. While `out_ready` is low, `out_valid` and `out_data` hold.
- R3: Every word inside a frame is checked for even parity over bits 16..0. Any failure sets status bit 0.
- R4: Status bit 1 is set when the bunch-crossing words of the two halves differ. Status bit 2 is set when their event-ID words differ. Each comparison covers the full 16-bit word.
- R5: One reference entry is popped from the reference FIFO per event, and the status word waits until an entry is present. Status bit 3 is set when half A's bunch-crossing word differs from the zero-extended `ref_bcid`. Status bit 4 is set when half A's event-ID word differs from the zero-extended `ref_evid`.
- R6: If the trailer word of either half is not 16'hE0E5, status bit 5 is set. Words are then discarded on half A until the next start marker, and discarded words are never forwarded.
- R7: The status word appears on `stat_word` with `stat_valid` high for exactly one cycle. It appears only after the last data word of its event has left the output register.
- R8: An event with any error is forwarded in full. It produces exactly 2 × CH_PER_HALF × `cfg_samples` output words.
- R9: After reset, the block is in the following state:
  - `out_valid` and `stat_valid` are low;
  - `ref_ready` is high;
  - the block waits for a start marker on half A (`a_ready` high, `b_ready` low).
- R10: `cfg_samples` is sampled when half A's start marker is accepted. A value of 0 gives an event with no data words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_samples | input | SAMP_W | Samples per channel for the next event |
| a_valid | input | 1 | Half A word valid |
| a_ready | output | 1 | Half A word accepted |
| a_word | input | DW+1 | Half A word, parity in the top bit |
| b_valid | input | 1 | Half B word valid |
| b_ready | output | 1 | Half B word accepted |
| b_word | input | DW+1 | Half B word, parity in the top bit |
| ref_valid | input | 1 | Reference ID pair valid |
| ref_ready | output | 1 | Reference FIFO has room |
| ref_bcid | input | BCID_W | Reference bunch-crossing ID |
| ref_evid | input | EVID_W | Reference event ID |
| out_valid | output | 1 | Forwarded data valid |
| out_ready | input | 1 | Downstream accepts data |
| out_data | output | DW | Forwarded channel data |
| stat_valid | output | 1 | One-cycle status strobe |
| stat_word | output | 6 | Per-event status bits |

## Verification
The input ready signals depend only on registered state and on `out_ready`. The bench therefore samples them one time unit after the falling edge, and counts a transfer at the next rising edge. A forwarded word is registered once, so it is visible on `out_data` one cycle after its input word is accepted. The bench records it in the falling-edge half of each cycle in which `out_valid` and `out_ready` are both high. The status strobe comes one cycle after the output register has drained and a reference entry is present. The bench takes it at the falling edge during that one-cycle pulse, together with the number of data words received so far. This lets R7's ordering and R8's word count be checked on the same sample.

// File: rtl/evt_frame_pkg.sv
package evt_frame_pkg;
  typedef enum logic [2:0] {
    ST_SOE,
    ST_BCID,
    ST_EVID,
    ST_DATA,
    ST_EOE,
    ST_STAT
  } seq_state_t;

  localparam int STAT_W = 6;
  localparam int SB_PAR = 0;
  localparam int SB_HBC = 1;
  localparam int SB_HEV = 2;
  localparam int SB_RBC = 3;
  localparam int SB_REV = 4;
  localparam int SB_FRM = 5;
endpackage

// File: rtl/evt_ref_fifo.sv
module evt_ref_fifo #(
  parameter int W     = 28,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_valid,
  output logic         wr_ready,
  input  logic [W-1:0] wr_data,
  input  logic         rd_en,
  output logic         rd_avail,
  output logic [W-1:0] rd_data
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [AW:0]   count;
  logic          wr_en;

  assign wr_ready = (count != (AW+1)'(DEPTH));
  assign rd_avail = (count != '0);
  assign wr_en    = wr_valid && wr_ready;
  assign rd_data  = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (wr_en) wr_ptr <= (wr_ptr == AW'(DEPTH-1)) ? '0 : wr_ptr + AW'(1);
      if (rd_en) rd_ptr <= (rd_ptr == AW'(DEPTH-1)) ? '0 : rd_ptr + AW'(1);
      case ({wr_en, rd_en})
        2'b10:   count <= count + (AW+1)'(1);
        2'b01:   count <= count - (AW+1)'(1);
        default: count <= count;
      endcase
    end
  end

  // R5
  ref_no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    count <= (AW+1)'(DEPTH));

  // R5
  ref_no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
    rd_en |-> (count != '0));
endmodule

// File: rtl/evt_word_check.sv
module evt_word_check #(
  parameter int          DW       = 16,
  parameter logic [15:0] SOE_MARK = 16'hB0E5,
  parameter logic [15:0] EOE_MARK = 16'hE0E5
) (
  input  logic [DW:0] word,
  output logic        par_ok,
  output logic        is_soe,
  output logic        is_eoe
);
  assign par_ok = ~(^word);
  assign is_soe = (word[DW-1:0] == DW'(SOE_MARK));
  assign is_eoe = (word[DW-1:0] == DW'(EOE_MARK));
endmodule

// File: rtl/evt_frame_seq.sv
module evt_frame_seq
  import evt_frame_pkg::*;
#(
  parameter int DW          = 16,
  parameter int CH_PER_HALF = 64,
  parameter int SAMP_W      = 3,
  parameter int BCID_W      = 12,
  parameter int EVID_W      = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SAMP_W-1:0] cfg_samples,
  input  logic              a_valid,
  input  logic              b_valid,
  input  logic [DW-1:0]     a_data,
  input  logic [DW-1:0]     b_data,
  input  logic [1:0]        par_ok,
  input  logic [1:0]        is_soe,
  input  logic [1:0]        is_eoe,
  output logic              a_ready,
  output logic              b_ready,
  input  logic              ref_avail,
  input  logic [BCID_W-1:0] ref_bcid,
  input  logic [EVID_W-1:0] ref_evid,
  output logic              ref_pop,
  input  logic              out_busy,
  input  logic              load_ok,
  output logic              data_load,
  output logic [DW-1:0]     data_word,
  output logic              stat_fire,
  output logic [STAT_W-1:0] stat_bits
);
  localparam int MAX_WORDS = CH_PER_HALF * ((1 << SAMP_W) - 1);
  localparam int CNT_W     = $clog2(MAX_WORDS + 1);

  seq_state_t       state;
  logic             side;
  logic [CNT_W-1:0] cnt, exp_cnt, cnt_nxt;
  logic [DW-1:0]    bc_a, bc_b, ev_a, ev_b;
  logic             par_err, frm_err;

  logic          cur_valid, cur_par_ok, cur_soe, cur_eoe, accept_en, take;
  logic [DW-1:0] cur_data, ref_bc_ext, ref_ev_ext;

  assign cur_valid  = side ? b_valid   : a_valid;
  assign cur_data   = side ? b_data    : a_data;
  assign cur_par_ok = side ? par_ok[1] : par_ok[0];
  assign cur_soe    = side ? is_soe[1] : is_soe[0];
  assign cur_eoe    = side ? is_eoe[1] : is_eoe[0];

  assign accept_en = (state != ST_STAT) && ((state != ST_DATA) || load_ok);
  assign a_ready   = accept_en && !side;
  assign b_ready   = accept_en && side;
  assign take      = accept_en && cur_valid;
  assign data_load = take && (state == ST_DATA);
  assign data_word = cur_data;
  assign cnt_nxt   = cnt + CNT_W'(1);

  assign stat_fire = (state == ST_STAT) && ref_avail && !out_busy;
  assign ref_pop   = stat_fire;

  assign ref_bc_ext = DW'(ref_bcid);
  assign ref_ev_ext = DW'(ref_evid);

  always_comb begin
    stat_bits         = '0;
    stat_bits[SB_PAR] = par_err;
    stat_bits[SB_HBC] = (bc_a != bc_b);
    stat_bits[SB_HEV] = (ev_a != ev_b);
    stat_bits[SB_RBC] = (bc_a != ref_bc_ext);
    stat_bits[SB_REV] = (ev_a != ref_ev_ext);
    stat_bits[SB_FRM] = frm_err;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_SOE;
      side    <= 1'b0;
      cnt     <= '0;
      exp_cnt <= '0;
      bc_a    <= '0;
      bc_b    <= '0;
      ev_a    <= '0;
      ev_b    <= '0;
      par_err <= 1'b0;
      frm_err <= 1'b0;
    end else begin
      case (state)
        ST_SOE: begin
          if (take && cur_soe) begin
            if (!side) begin
              par_err <= !cur_par_ok;
              frm_err <= 1'b0;
              exp_cnt <= CNT_W'(CH_PER_HALF) * CNT_W'(cfg_samples);
              side    <= 1'b1;
            end else begin
              par_err <= par_err | !cur_par_ok;
              side    <= 1'b0;
              state   <= ST_BCID;
            end
          end
        end
        ST_BCID: begin
          if (take) begin
            par_err <= par_err | !cur_par_ok;
            if (!side) bc_a <= cur_data;
            else begin
              bc_b  <= cur_data;
              state <= ST_EVID;
            end
            side <= !side;
          end
        end
        ST_EVID: begin
          if (take) begin
            par_err <= par_err | !cur_par_ok;
            if (!side) ev_a <= cur_data;
            else begin
              ev_b  <= cur_data;
              cnt   <= '0;
              state <= (exp_cnt == '0) ? ST_EOE : ST_DATA;
            end
            side <= !side;
          end
        end
        ST_DATA: begin
          if (take) begin
            par_err <= par_err | !cur_par_ok;
            if (side) begin
              cnt <= cnt_nxt;
              if (cnt_nxt == exp_cnt) state <= ST_EOE;
            end
            side <= !side;
          end
        end
        ST_EOE: begin
          if (take) begin
            par_err <= par_err | !cur_par_ok;
            if (!cur_eoe) frm_err <= 1'b1;
            if (side) state <= ST_STAT;
            side <= !side;
          end
        end
        ST_STAT: begin
          if (stat_fire) state <= ST_SOE;
        end
        default: state <= ST_SOE;
      endcase
    end
  end

  // R1
  one_side_ready_chk: assert property (@(posedge clk) disable iff (rst)
    !(a_ready && b_ready));

  // R8
  data_only_in_frame_chk: assert property (@(posedge clk) disable iff (rst)
    data_load |-> (cnt < exp_cnt));
endmodule

// File: rtl/evt_out_stage.sv
module evt_out_stage
  import evt_frame_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DW-1:0]     load_data,
  output logic              load_ok,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [DW-1:0]     out_data,
  input  logic              stat_fire,
  input  logic [STAT_W-1:0] stat_bits,
  output logic              stat_valid,
  output logic [STAT_W-1:0] stat_word
);
  assign load_ok = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_data   <= '0;
      stat_valid <= 1'b0;
      stat_word  <= '0;
    end else begin
      if (load) begin
        out_valid <= 1'b1;
        out_data  <= load_data;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
      stat_valid <= stat_fire;
      if (stat_fire) stat_word <= stat_bits;
    end
  end

  // R2
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R7
  stat_after_data_chk: assert property (@(posedge clk) disable iff (rst)
    stat_valid |-> !out_valid);

  // R7
  stat_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    stat_valid |=> !stat_valid);
endmodule

// File: rtl/evt_frame_checker.sv
module evt_frame_checker
  import evt_frame_pkg::*;
#(
  parameter int          DW          = 16,
  parameter int          CH_PER_HALF = 64,
  parameter int          SAMP_W      = 3,
  parameter int          BCID_W      = 12,
  parameter int          EVID_W      = 16,
  parameter int          REF_DEPTH   = 8,
  parameter logic [15:0] SOE_MARK    = 16'hB0E5,
  parameter logic [15:0] EOE_MARK    = 16'hE0E5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SAMP_W-1:0] cfg_samples,
  input  logic              a_valid,
  output logic              a_ready,
  input  logic [DW:0]       a_word,
  input  logic              b_valid,
  output logic              b_ready,
  input  logic [DW:0]       b_word,
  input  logic              ref_valid,
  output logic              ref_ready,
  input  logic [BCID_W-1:0] ref_bcid,
  input  logic [EVID_W-1:0] ref_evid,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DW-1:0]     out_data,
  output logic              stat_valid,
  output logic [5:0]        stat_word
);
  localparam int REF_W = BCID_W + EVID_W;

  logic [DW:0]   side_word [2];
  logic [1:0]    par_ok, is_soe, is_eoe;
  logic          ref_avail, ref_pop, load_ok, data_load, stat_fire;
  logic [REF_W-1:0]  ref_head;
  logic [DW-1:0]     data_word;
  logic [STAT_W-1:0] stat_bits;

  assign side_word[0] = a_word;
  assign side_word[1] = b_word;

  for (genvar s = 0; s < 2; s++) begin : g_side
    evt_word_check #(
      .DW(DW), .SOE_MARK(SOE_MARK), .EOE_MARK(EOE_MARK)
    ) u_chk (
      .word  (side_word[s]),
      .par_ok(par_ok[s]),
      .is_soe(is_soe[s]),
      .is_eoe(is_eoe[s])
    );
  end

  evt_ref_fifo #(.W(REF_W), .DEPTH(REF_DEPTH)) u_ref (
    .clk     (clk),
    .rst     (rst),
    .wr_valid(ref_valid),
    .wr_ready(ref_ready),
    .wr_data ({ref_bcid, ref_evid}),
    .rd_en   (ref_pop),
    .rd_avail(ref_avail),
    .rd_data (ref_head)
  );

  evt_frame_seq #(
    .DW(DW), .CH_PER_HALF(CH_PER_HALF), .SAMP_W(SAMP_W),
    .BCID_W(BCID_W), .EVID_W(EVID_W)
  ) u_seq (
    .clk        (clk),
    .rst        (rst),
    .cfg_samples(cfg_samples),
    .a_valid    (a_valid),
    .b_valid    (b_valid),
    .a_data     (a_word[DW-1:0]),
    .b_data     (b_word[DW-1:0]),
    .par_ok     (par_ok),
    .is_soe     (is_soe),
    .is_eoe     (is_eoe),
    .a_ready    (a_ready),
    .b_ready    (b_ready),
    .ref_avail  (ref_avail),
    .ref_bcid   (ref_head[REF_W-1:EVID_W]),
    .ref_evid   (ref_head[EVID_W-1:0]),
    .ref_pop    (ref_pop),
    .out_busy   (out_valid),
    .load_ok    (load_ok),
    .data_load  (data_load),
    .data_word  (data_word),
    .stat_fire  (stat_fire),
    .stat_bits  (stat_bits)
  );

  evt_out_stage #(.DW(DW)) u_out (
    .clk       (clk),
    .rst       (rst),
    .load      (data_load),
    .load_data (data_word),
    .load_ok   (load_ok),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_data  (out_data),
    .stat_fire (stat_fire),
    .stat_bits (stat_bits),
    .stat_valid(stat_valid),
    .stat_word (stat_word)
  );
endmodule

// File: tb/tb_evt_frame_checker.sv
`timescale 1ns/1ps
module tb_evt_frame_checker;
  localparam int DW = 16;
  localparam int CH = 2;
  localparam int SAMP_W = 3;
  localparam int BCID_W = 12;
  localparam int EVID_W = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [SAMP_W-1:0] cfg_samples = '0;
  logic a_valid = 1'b0, b_valid = 1'b0, ref_valid = 1'b0, out_ready = 1'b1;
  logic [DW:0] a_word = '0, b_word = '0;
  logic [BCID_W-1:0] ref_bcid = '0;
  logic [EVID_W-1:0] ref_evid = '0;
  logic a_ready, b_ready, ref_ready, out_valid, stat_valid;
  logic [DW-1:0] out_data;
  logic [5:0] stat_word;

  always #2.5 clk = ~clk;

  evt_frame_checker #(
    .DW(DW), .CH_PER_HALF(CH), .SAMP_W(SAMP_W),
    .BCID_W(BCID_W), .EVID_W(EVID_W), .REF_DEPTH(4)
  ) dut (
    .clk(clk), .rst(rst), .cfg_samples(cfg_samples),
    .a_valid(a_valid), .a_ready(a_ready), .a_word(a_word),
    .b_valid(b_valid), .b_ready(b_ready), .b_word(b_word),
    .ref_valid(ref_valid), .ref_ready(ref_ready),
    .ref_bcid(ref_bcid), .ref_evid(ref_evid),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .stat_valid(stat_valid), .stat_word(stat_word)
  );

  int checks = 0;
  int failures = 0;
  int data_cnt = 0;
  int stat_cnt = 0;
  int cyc = 0;
  bit throttle = 1'b0;
  logic [15:0] got_data [0:1023];
  logic [5:0]  got_stat [0:63];
  int          got_dcnt [0:63];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] dword(input int e, input int side, input int i);
    return {4'(e), 1'(side), 11'(i)};
  endfunction

  function automatic int frame_len(input int samp, input int extra, input int junk);
    return junk + 3 + CH * samp + extra + 1;
  endfunction

  function automatic logic [16:0] mkword(input int side, input int e, input int bc,
      input int ev, input int samp, input int bad, input int junk, input int k);
    logic [15:0] d;
    logic flip;
    int n, j;
    n = CH * samp;
    flip = 1'b0;
    j = k - junk;
    if (k < junk) d = 16'h1234;
    else if (j == 0) d = 16'hB0E5;
    else if (j == 1) d = 16'(bc);
    else if (j == 2) d = 16'(ev);
    else if (j == frame_len(samp, 0, 0) + (k - k) - 1 + 0 && 0) d = 16'h0;
    else d = 16'h0;
    if (k >= junk && j >= 3) begin
      d = dword(e, side, j - 3);
      if ((j - 3) == bad) flip = 1'b1;
    end
    return {(^d) ^ flip, d};
  endfunction

  task automatic send_a(input int e, input int bc, input int ev, input int samp,
      input int extra, input int bad, input int junk);
    int len;
    len = frame_len(samp, extra, junk);
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      a_valid = 1'b1;
      if (k == len - 1) a_word = {^16'hE0E5, 16'hE0E5};
      else a_word = mkword(0, e, bc, ev, samp, bad, junk, k);
      #1;
      while (!a_ready) begin @(negedge clk); #1; end
      @(posedge clk);
    end
    @(negedge clk);
    a_valid = 1'b0;
  endtask

  task automatic send_b(input int e, input int bc, input int ev, input int samp,
      input int bad);
    int len;
    len = frame_len(samp, 0, 0);
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      b_valid = 1'b1;
      if (k == len - 1) b_word = {^16'hE0E5, 16'hE0E5};
      else b_word = mkword(1, e, bc, ev, samp, bad, 0, k);
      #1;
      while (!b_ready) begin @(negedge clk); #1; end
      @(posedge clk);
    end
    @(negedge clk);
    b_valid = 1'b0;
  endtask

  task automatic push_ref(input int bc, input int ev);
    @(negedge clk);
    ref_valid = 1'b1;
    ref_bcid = BCID_W'(bc);
    ref_evid = EVID_W'(ev);
    #1;
    while (!ref_ready) begin @(negedge clk); #1; end
    @(posedge clk);
    @(negedge clk);
    ref_valid = 1'b0;
  endtask

  always begin
    @(negedge clk);
    cyc++;
    out_ready = throttle ? ((cyc % 3) != 0) : 1'b1;
    #1;
    if (out_valid && out_ready) begin
      got_data[data_cnt] = out_data;
      data_cnt++;
    end
  end

  always begin
    @(negedge clk);
    #1;
    if (stat_valid) begin
      got_stat[stat_cnt] = stat_word;
      got_dcnt[stat_cnt] = data_cnt;
      stat_cnt++;
    end
  end

  task automatic run_event(input int e, input int samp, input int bca, input int eva,
      input int bcb, input int evb, input int rbc, input int rev, input int bada,
      input int badb, input int extra_a, input int junk_a, input bit thr, input string tag);
    int base, sbase, n;
    logic [5:0] exp_st;
    n = CH * samp;
    throttle = thr;
    cfg_samples = SAMP_W'(samp);
    push_ref(rbc, rev);
    base = data_cnt;
    sbase = stat_cnt;
    fork
      send_a(e, bca, eva, samp, extra_a, bada, junk_a);
      send_b(e, bcb, evb, samp, badb);
    join
    while (stat_cnt == sbase) @(negedge clk);
    exp_st = '0;
    exp_st[0] = ((bada >= 0) && (bada < n)) || ((badb >= 0) && (badb < n));
    exp_st[1] = (bca != bcb);
    exp_st[2] = (eva != evb);
    exp_st[3] = (bca != rbc);
    exp_st[4] = (eva != rev);
    exp_st[5] = (extra_a > 0);
    chk(got_stat[sbase] == exp_st, {tag, " status R3 R4 R5 R6"}, got_stat[sbase], exp_st);
    chk(got_dcnt[sbase] == base + 2 * n, {tag, " R7 R8 data before status"},
        got_dcnt[sbase] - base, 2 * n);
    for (int i = 0; i < n; i++) begin
      chk(got_data[base + 2*i] == dword(e, 0, i), {tag, " R1 R2 half A word"},
          got_data[base + 2*i], dword(e, 0, i));
      chk(got_data[base + 2*i + 1] == dword(e, 1, i), {tag, " R2 R10 half B word"},
          got_data[base + 2*i + 1], dword(e, 1, i));
    end
    repeat (4) @(negedge clk);
    chk(data_cnt == base + 2 * n, {tag, " R6 no extra words forwarded"}, data_cnt - base, 2 * n);
    chk(stat_cnt == sbase + 1, {tag, " R7 single status"}, stat_cnt - sbase, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    #1;
    chk(out_valid == 1'b0, "R9 out_valid", out_valid, 0);
    chk(stat_valid == 1'b0, "R9 stat_valid", stat_valid, 0);
    chk(a_ready == 1'b1, "R9 a_ready", a_ready, 1);
    chk(b_ready == 1'b0, "R9 b_ready", b_ready, 0);
    chk(ref_ready == 1'b1, "R9 ref_ready", ref_ready, 1);

    run_event(1, 3, 12'h101, 16'h0011, 12'h101, 16'h0011, 12'h101, 16'h0011, -1, -1, 0, 0, 0, "e1 clean");
    run_event(2, 1, 12'h202, 16'h0022, 12'h202, 16'h0022, 12'h202, 16'h0022, -1, -1, 0, 0, 1, "e2 throttled");
    run_event(3, 5, 12'h303, 16'h0033, 12'h30F, 16'h0033, 12'h303, 16'h0033, -1, -1, 0, 0, 0, "e3 R4 half bcid");
    run_event(4, 2, 12'h404, 16'h0044, 12'h404, 16'h0F44, 12'h404, 16'h0044, -1, -1, 0, 0, 0, "e4 R4 half evid");
    run_event(5, 1, 12'h505, 16'h0055, 12'h505, 16'h0055, 12'h5A5, 16'h0055, -1, -1, 0, 0, 0, "e5 R5 ref bcid");
    run_event(6, 2, 12'h606, 16'h0066, 12'h606, 16'h0066, 12'h606, 16'hF066, -1, -1, 0, 0, 1, "e6 R5 ref evid");
    run_event(7, 3, 12'h707, 16'h0077, 12'h707, 16'h0077, 12'h707, 16'h0077, -1, 2, 0, 0, 0, "e7 R3 R8 parity B");
    run_event(8, 2, 12'h808, 16'h0088, 12'h808, 16'h0C88, 12'h808, 16'h0088, 0, -1, 0, 0, 1, "e8 R3 R8 parity A");
    run_event(9, 2, 12'h909, 16'h0099, 12'h909, 16'h0099, 12'h909, 16'h0099, -1, -1, 2, 0, 0, "e9 R6 long frame");
    run_event(10, 7, 12'hA0A, 16'h00AA, 12'hA0A, 16'h00AA, 12'hA0A, 16'h00AA, -1, -1, 0, 2, 1, "e10 R6 resync junk");
    run_event(11, 0, 12'hB0B, 16'h00BB, 12'hB0B, 16'h00BB, 12'hB0B, 16'h00BB, -1, -1, 0, 0, 0, "e11 R10 zero samples");
    run_event(12, 4, 12'hC0C, 16'h00CC, 12'hC0C, 16'h00CC, 12'hC0C, 16'h00CC, -1, -1, 0, 0, 1, "e12 R1 clean");

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule